// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous burst memory. At the start of a burst, a load strobe captures a full external address. After that, every clock edge with the advance strobe high moves the two lowest address bits to the next beat position. An edge with advance low leaves the address where it is, which suspends the burst. The bits above bit 1 keep the captured value for the whole burst.

A static order input picks one of two beat orders. The interleaved order XORs the start offset with the beat count. The linear order adds the beat count to the start offset and wraps inside the aligned group of four words. The output address comes straight from the captured base and the beat counter, so it is valid in the cycle after the edge that changed it.

The memory array, command decoding and output timing sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `addr` to all zeros from the next cycle onward, including in the middle of a burst.
- R2: A rising edge with `load` high captures `load_addr`, and `addr` equals it in the following cycle (beat 0).
- R3: When `load` and `adv` are both high at the same edge, the load wins: `addr` equals the new `load_addr` and the beat offset restarts at zero.
- R4: With `order_il` = 1 (interleaved), beat k has `addr[1:0]` = start[1:0] XOR k. For example, start 01 gives 01, 00, 11, 10.
- R5: With `order_il` = 0 (linear), beat k has `addr[1:0]` = (start[1:0] + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R6: `addr[ADDR_W-1:2]` keeps the loaded value across every advance, including the wrap from 11 to 00. No carry reaches bit 2.
- R7: An edge with `load` and `adv` both low leaves `addr` unchanged (suspend).
- R8: After the fourth beat, a further advance returns to the start offset, and the sequence keeps cycling through the same four positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Starts a burst by capturing `load_addr` |
| load_addr | input | ADDR_W | External start address |
| adv | input | 1 | Advances to the next beat when high; holds the address when low |
| order_il | input | 1 | 1 selects the interleaved order, 0 the linear order; must stay constant during a burst |
| addr | output | ADDR_W | Current burst address |

## Verification
Burst start and beat advance can fall in the same cycle. The bench provokes this by holding `adv` high on the very edge that raises `load`, in the middle of a burst that was already advancing. The result is correct only if `addr` shows the fresh load address exactly, with no step applied, and the following advance then goes to beat 1 of the new burst. Reset and advance can also coincide: a reset during an advancing burst must leave an all-zero address.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)       base <= '0;
    else if (load) base <= load_addr;
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] offset
);
  // The load restarts the count and takes priority over adv.
  // The count wraps freely, so the burst keeps cycling.
  always_ff @(posedge clk) begin
    if (rst || load) offset <= '0;
    else if (adv)    offset <= offset + 1'b1;
  end
endmodule

// File: rtl/bsq_low_map.sv
module bsq_low_map
  import bsq_pkg::*;
(
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] offset,
  input  order_e            order,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] il_low;
  logic [BEAT_W-1:0] lin_low;

  // Interleaved order: each bit flips on its own, with no carry between bits.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_il_bit
    assign il_low[b] = start[b] ^ offset[b];
  end

  // Linear order: add inside the beat field; the carry out is dropped, so it wraps.
  assign lin_low = start + offset;

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: low = il_low;
      default:        low = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  input  logic              order_il,
  output logic [ADDR_W-1:0] addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] offset;
  logic [BEAT_W-1:0] low;

  bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr), .base(base)
  );

  bsq_beat_ctr u_ctr (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .offset(offset)
  );

  bsq_low_map u_map (
    .start(base[BEAT_W-1:0]), .offset(offset),
    .order(order_e'(order_il)), .low(low)
  );

  assign addr = {base[ADDR_W-1 -: UPPER_W], low};
endmodule

// File: rtl/bsq_checker.sv
module bsq_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [ADDR_W-1:0] load_addr,
  input logic              adv,
  input logic              order_il,
  input logic [ADDR_W-1:0] addr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> addr == '0);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> addr == $past(load_addr));

  // R3
  load_over_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (load && adv) |=> addr[1:0] == $past(load_addr[1:0]));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && !order_il) |=>
      (order_il || addr[1:0] == $past(addr[1:0]) + 2'd1));

  // R4
  interleave_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && order_il) |=>
      (!order_il || addr[1:0] != $past(addr[1:0])));

  // R6
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> addr[ADDR_W-1:2] == $past(addr[ADDR_W-1:2]));

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> (order_il != $past(order_il) || $stable(addr)));
endmodule

bind burst_addr_seq bsq_checker #(.ADDR_W(ADDR_W)) u_bsq_chk (
  .clk(clk), .rst(rst), .load(load), .load_addr(load_addr),
  .adv(adv), .order_il(order_il), .addr(addr)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst, load, adv, order_il;
  logic [AW-1:0] load_addr;
  logic [AW-1:0] addr;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr),
    .adv(adv), .order_il(order_il), .addr(addr)
  );

  // Reference table: order, start offset, then beats 0..3 packed two bits each, beat 0 first.
  localparam logic       V_ORD   [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [1:0] V_START [8] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [7:0] V_EXP   [8] = '{8'h1B, 8'h4E, 8'hB1, 8'hE4, 8'h1B, 8'h6C, 8'hB1, 8'hC6};

  task automatic chk(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr !== exp) begin
      failures++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; adv = 1'b0; order_il = 1'b1; load_addr = '0;
    tick(); tick();
    chk("R1 reset", '0);
    rst = 1'b0;

    // Table walk: every start offset in both orders, plus the cycle back (R8).
    for (int v = 0; v < 8; v++) begin
      logic [AW-3:0] up;
      up = 18'h2ABC0 + 18'(v);
      order_il = V_ORD[v];
      load = 1'b1; load_addr = {up, V_START[v]};
      tick();
      load = 1'b0; adv = 1'b1;
      chk("R2 load beat0", {up, V_EXP[v][7:6]});
      for (int k = 1; k < 4; k++) begin
        tick();
        chk(V_ORD[v] ? "R4 interleaved beat" : "R5 linear beat",
            {up, V_EXP[v][7-2*k -: 2]});
      end
      tick();
      chk("R8 cycles back to start", {up, V_START[v]});
      adv = 1'b0;
    end

    // R7 suspend: hold for three edges, then resume.
    order_il = 1'b0;
    load = 1'b1; load_addr = 20'h12342; tick();
    load = 1'b0; adv = 1'b1; tick();
    adv = 1'b0;
    chk("R7 before suspend", 20'h12343);
    tick(); tick(); tick();
    chk("R7 suspend hold", 20'h12343);
    adv = 1'b1; tick();
    chk("R6 wrap keeps upper bits", 20'h12340);

    // R6: all-ones upper bits through the wrap in linear order.
    load = 1'b1; load_addr = 20'hFFFFF; adv = 1'b0; tick();
    load = 1'b0; adv = 1'b1; tick();
    chk("R6 no carry into bit 2", 20'hFFFFC);

    // R3: load and advance at the same edge, mid burst.
    order_il = 1'b1;
    load = 1'b1; load_addr = 20'h0A001; tick();
    load = 1'b0; adv = 1'b1; tick();
    load = 1'b1; load_addr = 20'h55556; tick();
    load = 1'b0;
    chk("R3 load overrides adv", 20'h55556);
    tick();
    chk("R3 next beat is beat1", 20'h55557);

    // R1: reset in the middle of an advancing burst.
    rst = 1'b1; tick();
    rst = 1'b0; adv = 1'b0;
    chk("R1 reset mid burst", '0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule